// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves address translations that missed in a translation buffer. Given a 32-bit virtual address, an access kind (read or write) and a privilege level (user or supervisor), it fetches the directory entry selected by the top ten address bits from a directory whose frame number is supplied on a base input. It then either maps a 4 MB region straight from that entry or fetches the table entry selected by the next ten bits. It checks presence and permissions and returns a physical address with the final page attributes, or a fault with its cause.

On a successful walk the block keeps the in-memory entries current: it sets the accessed bit in every entry it used and sets the dirty bit in the final entry on a write. Each entry is written back only if one of those bits actually changes. All write-backs finish before the response is given. The memory port carries one request at a time, and the walker accepts a new request only while idle.

Entry bit positions used throughout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 write-through, bit 4 cache-disable, bit 5 accessed, bit 6 dirty, bit 7 large page (directory only), bit 8 global, bits 31..12 frame number.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from {base frame, va[31:22], 2'b00}; the table entry is read from {directory entry[31:12], va[21:12], 2'b00}.
- R2: If bit 0 of the directory entry, or of the table entry when one is read, is 0, the walk ends in a fault with flt_prot_o=0, and no further read or write is made.
- R3: A present directory entry with bit 7 set maps a 4 MB page: no table read occurs, and the physical address is {entry[31:22], va[21:0]} with rsp_big_o=1.
- R4: For a 4 KB page the physical address is {table entry[31:12], va[11:0]} with rsp_big_o=0.
- R5: Effective writable and user permissions are the AND of bits 1 and 2 over the entries used. A write without effective write permission, or a user access without effective user permission, ends in a fault with flt_prot_o=1. A supervisor read never faults on permissions.
- R6: On success, bit 5 is set in every entry used and bit 6 in the final entry on a write. An entry is written back only if its value changes, directory before table, and all write-backs finish before the response. rsp_dirty_o reports the final entry's updated bit 6.
- R7: A walk that faults writes nothing to memory.
- R8: A fault response carries rsp_fault_o=1, the faulting virtual address on rsp_vaddr_o, and flt_write_o and flt_user_o equal to the request's write and user inputs.
- R9: mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o hold steady until mem_ack_i. req_ready_o is high only while idle. Each request gives exactly one rsp_valid_o pulse of one cycle.
- R10: After reset req_ready_o=1, mem_req_o=0 and rsp_valid_o=0.
- R11: On success rsp_global_o, rsp_nocache_o and rsp_wthru_o give bits 8, 4 and 3 of the final entry, and rsp_writable_o and rsp_user_o give the effective permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| dir_base_i | input | 20 | Frame number of the directory |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write-back |
| mem_addr_o | output | 32 | Entry byte address |
| mem_wdata_o | output | 32 | Updated entry |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_vaddr_o | output | 32 | Virtual address of the walk |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_big_o | output | 1 | 4 MB mapping |
| rsp_writable_o | output | 1 | Effective write permission |
| rsp_user_o | output | 1 | Effective user permission |
| rsp_dirty_o | output | 1 | Final entry dirty after update |
| rsp_global_o | output | 1 | Final entry global bit |
| rsp_nocache_o | output | 1 | Final entry cache-disable bit |
| rsp_wthru_o | output | 1 | Final entry write-through bit |
| flt_prot_o | output | 1 | Fault cause: 1 protection, 0 not present |
| flt_write_o | output | 1 | Faulting access was a write |
| flt_user_o | output | 1 | Faulting access was from user mode |

## Verification
The bench goes after walks that need both write-backs, only one, or none, and repeats a write to show that an already dirty entry is left alone. A design that ignored the change test would issue extra memory writes that the access-by-access comparison rejects. Permission cases put the restriction on only one of the two levels, so a design that checks just the leaf lets a forbidden access through. Large-page walks and missing entries at either level catch a spurious table read, a wrong offset split, or a fault that still writes back accessed bits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned ENT_W     = 32;
  localparam int unsigned FRM_W     = VA_W - OFF_W;
  localparam int unsigned BIG_OFF_W = OFF_W + IDX_W;
  localparam int unsigned BIG_FRM_W = VA_W - BIG_OFF_W;
  localparam int unsigned ENT_LG    = $clog2(ENT_W / 8);

  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_WT = 3;
  localparam int unsigned BIT_CD = 4;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;
  localparam int unsigned BIT_PS = 7;
  localparam int unsigned BIT_G  = 8;

  typedef logic [ENT_W-1:0] ent_t;
  typedef logic [VA_W-1:0]  addr_t;
  typedef logic [FRM_W-1:0] frame_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_UPDATE, ST_DONE, ST_FAULT
  } walk_st_e;

  typedef struct packed {
    logic writable;
    logic user;
    logic dirty;
    logic global_pg;
    logic no_cache;
    logic wr_thru;
  } attr_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  frame_t dir_frame_i,
  input  frame_t tbl_frame_i,
  input  logic [IDX_W-1:0] dir_idx_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  output addr_t  dir_addr_o,
  output addr_t  tbl_addr_o
);
  assign dir_addr_o = {dir_frame_i, dir_idx_i, {ENT_LG{1'b0}}};
  assign tbl_addr_o = {tbl_frame_i, tbl_idx_i, {ENT_LG{1'b0}}};
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  ent_t  pde_i,
  input  ent_t  pte_i,
  input  logic [BIG_OFF_W-1:0] va_off_i,
  input  logic  write_i,
  input  logic  user_i,
  output logic  big_o,
  output logic  dir_np_o,
  output logic  tbl_np_o,
  output logic  prot_o,
  output ent_t  pde_new_o,
  output ent_t  pte_new_o,
  output logic  dir_chg_o,
  output logic  tbl_chg_o,
  output addr_t paddr_o,
  output attr_t attr_o
);
  logic eff_rw, eff_us;
  ent_t leaf, leaf_new;

  assign big_o    = pde_i[BIT_PS];
  assign dir_np_o = ~pde_i[BIT_P];
  assign tbl_np_o = ~pte_i[BIT_P];

  // a large page has no table level, so only the directory grants rights
  assign eff_rw = pde_i[BIT_RW] & (big_o | pte_i[BIT_RW]);
  assign eff_us = pde_i[BIT_US] & (big_o | pte_i[BIT_US]);
  assign prot_o = (write_i & ~eff_rw) | (user_i & ~eff_us);

  always_comb begin
    pde_new_o = pde_i;
    pde_new_o[BIT_A] = 1'b1;
    if (big_o && write_i) pde_new_o[BIT_D] = 1'b1;
    pte_new_o = pte_i;
    pte_new_o[BIT_A] = 1'b1;
    if (write_i) pte_new_o[BIT_D] = 1'b1;
  end

  assign dir_chg_o = (pde_new_o != pde_i);
  assign tbl_chg_o = ~big_o & (pte_new_o != pte_i);

  assign leaf     = big_o ? pde_i : pte_i;
  assign leaf_new = big_o ? pde_new_o : pte_new_o;

  assign paddr_o = big_o ? {pde_i[ENT_W-1 -: BIG_FRM_W], va_off_i}
                         : {pte_i[ENT_W-1 -: FRM_W], va_off_i[OFF_W-1:0]};

  always_comb begin
    attr_o.writable  = eff_rw;
    attr_o.user      = eff_us;
    attr_o.dirty     = leaf_new[BIT_D];
    attr_o.global_pg = leaf[BIT_G];
    attr_o.no_cache  = leaf[BIT_CD];
    attr_o.wr_thru   = leaf[BIT_WT];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  input  logic [FRM_W-1:0] dir_base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [VA_W-1:0]  mem_addr_o,
  output logic [ENT_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [VA_W-1:0]  rsp_vaddr_o,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_big_o,
  output logic             rsp_writable_o,
  output logic             rsp_user_o,
  output logic             rsp_dirty_o,
  output logic             rsp_global_o,
  output logic             rsp_nocache_o,
  output logic             rsp_wthru_o,
  output logic             flt_prot_o,
  output logic             flt_write_o,
  output logic             flt_user_o
);
  walk_st_e st_q, st_d;
  addr_t    va_q;
  frame_t   base_q;
  logic     wr_q, usr_q, prot_q;
  ent_t     pde_q, pte_q;
  logic     upd_dir_q, upd_tbl_q;

  ent_t  pde_cur, pte_cur, pde_new, pte_new;
  addr_t dir_addr, tbl_addr, paddr;
  logic  big, dir_np, tbl_np, prot, dir_chg, tbl_chg;
  attr_t attr;

  // entries are checked straight off the read data on the acknowledge cycle
  assign pde_cur = (st_q == ST_RD_DIR) ? mem_rdata_i : pde_q;
  assign pte_cur = (st_q == ST_RD_TBL) ? mem_rdata_i : pte_q;

  ptw_addr_gen u_addr (
    .dir_frame_i (base_q),
    .tbl_frame_i (pde_q[ENT_W-1 -: FRM_W]),
    .dir_idx_i   (va_q[VA_W-1 -: IDX_W]),
    .tbl_idx_i   (va_q[OFF_W +: IDX_W]),
    .dir_addr_o  (dir_addr),
    .tbl_addr_o  (tbl_addr)
  );

  ptw_entry_check u_chk_ent (
    .pde_i     (pde_cur),
    .pte_i     (pte_cur),
    .va_off_i  (va_q[BIG_OFF_W-1:0]),
    .write_i   (wr_q),
    .user_i    (usr_q),
    .big_o     (big),
    .dir_np_o  (dir_np),
    .tbl_np_o  (tbl_np),
    .prot_o    (prot),
    .pde_new_o (pde_new),
    .pte_new_o (pte_new),
    .dir_chg_o (dir_chg),
    .tbl_chg_o (tbl_chg),
    .paddr_o   (paddr),
    .attr_o    (attr)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid_i) st_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_ack_i) begin
        if (dir_np)       st_d = ST_FAULT;
        else if (!big)    st_d = ST_RD_TBL;
        else if (prot)    st_d = ST_FAULT;
        else if (dir_chg) st_d = ST_UPDATE;
        else              st_d = ST_DONE;
      end
      ST_RD_TBL: if (mem_ack_i) begin
        if (tbl_np || prot)       st_d = ST_FAULT;
        else if (dir_chg || tbl_chg) st_d = ST_UPDATE;
        else                      st_d = ST_DONE;
      end
      ST_UPDATE: if (mem_ack_i && !(upd_dir_q && upd_tbl_q)) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      ST_FAULT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      prot_q    <= 1'b0;
      pde_q     <= '0;
      pte_q     <= '0;
      upd_dir_q <= 1'b0;
      upd_tbl_q <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i;
          base_q <= dir_base_i;
          wr_q   <= req_write_i;
          usr_q  <= req_user_i;
        end
        ST_RD_DIR: if (mem_ack_i) begin
          pde_q     <= mem_rdata_i;
          prot_q    <= ~dir_np;
          upd_dir_q <= dir_chg;
          upd_tbl_q <= 1'b0;
        end
        ST_RD_TBL: if (mem_ack_i) begin
          pte_q     <= mem_rdata_i;
          prot_q    <= ~tbl_np;
          upd_dir_q <= dir_chg;
          upd_tbl_q <= tbl_chg;
        end
        ST_UPDATE: if (mem_ack_i) begin
          if (upd_dir_q) upd_dir_q <= 1'b0;
          else           upd_tbl_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  logic done, fault;
  assign done  = (st_q == ST_DONE);
  assign fault = (st_q == ST_FAULT);

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_RD_DIR) || (st_q == ST_RD_TBL) || (st_q == ST_UPDATE);
  assign mem_we_o    = (st_q == ST_UPDATE);

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_RD_DIR: mem_addr_o = dir_addr;
      ST_RD_TBL: mem_addr_o = tbl_addr;
      ST_UPDATE: begin
        mem_addr_o  = upd_dir_q ? dir_addr : tbl_addr;
        mem_wdata_o = upd_dir_q ? pde_new : pte_new;
      end
      default: ;
    endcase
  end

  assign rsp_valid_o    = done | fault;
  assign rsp_fault_o    = fault;
  assign rsp_vaddr_o    = va_q;
  assign rsp_paddr_o    = done ? paddr : '0;
  assign rsp_big_o      = done & big;
  assign rsp_writable_o = done & attr.writable;
  assign rsp_user_o     = done & attr.user;
  assign rsp_dirty_o    = done & attr.dirty;
  assign rsp_global_o   = done & attr.global_pg;
  assign rsp_nocache_o  = done & attr.no_cache;
  assign rsp_wthru_o    = done & attr.wr_thru;
  assign flt_prot_o     = fault & prot_q;
  assign flt_write_o    = fault & wr_q;
  assign flt_user_o     = fault & usr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [VA_W-1:0]  mem_addr_o,
  input logic [ENT_W-1:0] mem_wdata_o,
  input logic             mem_ack_i,
  input logic             rsp_valid_o,
  input logic             rsp_fault_o,
  input logic [VA_W-1:0]  rsp_vaddr_o,
  input logic [VA_W-1:0]  rsp_paddr_o,
  input logic             rsp_big_o,
  input logic             flt_prot_o,
  input logic             flt_write_o,
  input logic             flt_user_o
);
  a_r9_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r9_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);

  a_r6_wb_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[BIT_A]);

  a_r5_prot_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o && flt_prot_o |-> flt_write_o || flt_user_o);

  a_r7_fault_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o));

  a_r3_big_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && rsp_big_o |->
      rsp_paddr_o[BIG_OFF_W-1:0] == rsp_vaddr_o[BIG_OFF_W-1:0]);

  a_r4_small_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && !rsp_big_o |->
      rsp_paddr_o[OFF_W-1:0] == rsp_vaddr_o[OFF_W-1:0]);
endmodule

bind pt_walker pt_walker_chk u_walk_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_vaddr_o (rsp_vaddr_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_big_o   (rsp_big_o),
  .flt_prot_o  (flt_prot_o),
  .flt_write_o (flt_write_o),
  .flt_user_o  (flt_user_o)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] dir_base = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_big, rsp_writable, rsp_user, rsp_dirty;
  logic        rsp_global, rsp_nocache, rsp_wthru, flt_prot, flt_write, flt_user;
  logic [31:0] rsp_vaddr, rsp_paddr;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .dir_base_i(dir_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_vaddr_o(rsp_vaddr),
    .rsp_paddr_o(rsp_paddr), .rsp_big_o(rsp_big), .rsp_writable_o(rsp_writable),
    .rsp_user_o(rsp_user), .rsp_dirty_o(rsp_dirty), .rsp_global_o(rsp_global),
    .rsp_nocache_o(rsp_nocache), .rsp_wthru_o(rsp_wthru),
    .flt_prot_o(flt_prot), .flt_write_o(flt_write), .flt_user_o(flt_user)
  );

  logic [31:0] mem [logic [31:0]];
  logic [31:0] ex_addr [$];
  logic        ex_we [$];
  logic [31:0] ex_wd [$];
  int n_chk = 0, n_bad = 0, lat = 0, wcnt = 0, cyc = 0;
  logic [31:0] e_a, e_d;
  logic        e_w;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
    ex_addr.push_back(a); ex_we.push_back(w); ex_wd.push_back(d);
  endtask

  // memory model: acknowledges after lat idle cycles and compares each access
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = rd(mem_addr);
        if (ex_addr.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R7 unexpected access: actual %h expected none", mem_addr);
        end else begin
          e_a = ex_addr.pop_front(); e_w = ex_we.pop_front(); e_d = ex_wd.pop_front();
          chk("R1", "access address", mem_addr, e_a);
          chk("R6", "access kind", {31'b0, mem_we}, {31'b0, e_w});
          if (e_w) chk("R6", "write-back value", mem_wdata, e_d);
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
      end else wcnt++;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic walk(input logic [31:0] va, input bit w, input bit u,
                      input logic [19:0] base, input int l);
    logic [31:0] pde, pte, npde, npte, pde_a, pte_a, epa;
    bit ef, ep, eb, erw, eus, ed, eg, ecd, ewt;
    int t;
    lat = l;
    ef = 0; ep = 0; eb = 0; erw = 0; eus = 0; ed = 0; eg = 0; ecd = 0; ewt = 0; epa = '0;
    pde_a = {base, va[31:22], 2'b00};
    pde = rd(pde_a);
    push(pde_a, 1'b0, '0);
    if (!pde[0]) ef = 1;
    else if (pde[7]) begin
      eb = 1; erw = pde[1]; eus = pde[2];
      if ((w && !erw) || (u && !eus)) begin ef = 1; ep = 1; end
      else begin
        npde = pde | 32'h20 | (w ? 32'h40 : 32'h0);
        if (npde != pde) push(pde_a, 1'b1, npde);
        epa = {pde[31:22], va[21:0]};
        ed = npde[6]; eg = pde[8]; ecd = pde[4]; ewt = pde[3];
      end
    end else begin
      pte_a = {pde[31:12], va[21:12], 2'b00};
      pte = rd(pte_a);
      push(pte_a, 1'b0, '0);
      if (!pte[0]) ef = 1;
      else begin
        erw = pde[1] & pte[1]; eus = pde[2] & pte[2];
        if ((w && !erw) || (u && !eus)) begin ef = 1; ep = 1; end
        else begin
          npde = pde | 32'h20;
          npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
          if (npde != pde) push(pde_a, 1'b1, npde);
          if (npte != pte) push(pte_a, 1'b1, npte);
          epa = {pte[31:12], va[11:0]};
          ed = npte[6]; eg = pte[8]; ecd = pte[4]; ewt = pte[3];
        end
      end
    end

    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u; dir_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "ready while busy", {31'b0, req_ready}, 32'd0);
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    chk("R9", "response arrives", {31'b0, rsp_valid}, 32'd1);
    chk("R8", "fault flag", {31'b0, rsp_fault}, {31'b0, ef});
    chk("R6", "accesses outstanding at response", ex_addr.size(), 32'd0);
    if (ef) begin
      chk("R8", "fault address", rsp_vaddr, va);
      chk(ep ? "R5" : "R2", "fault cause", {31'b0, flt_prot}, {31'b0, ep});
      chk("R8", "fault write", {31'b0, flt_write}, {31'b0, w});
      chk("R8", "fault user", {31'b0, flt_user}, {31'b0, u});
    end else begin
      chk(eb ? "R3" : "R4", "physical address", rsp_paddr, epa);
      chk("R3", "large page flag", {31'b0, rsp_big}, {31'b0, eb});
      chk("R5", "writable", {31'b0, rsp_writable}, {31'b0, erw});
      chk("R5", "user", {31'b0, rsp_user}, {31'b0, eus});
      chk("R6", "dirty", {31'b0, rsp_dirty}, {31'b0, ed});
      chk("R11", "attributes", {29'b0, rsp_global, rsp_nocache, rsp_wthru},
          {29'b0, eg, ecd, ewt});
    end
    @(negedge clk);
    chk("R9", "one-cycle response", {31'b0, rsp_valid}, 32'd0);
    ex_addr.delete(); ex_we.delete(); ex_wd.delete();
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h0002_0027;
    mem[32'h0002_000C] = 32'h1234_5027;
    mem[32'h0001_0008] = 32'h0002_1007;
    mem[32'h0002_1014] = 32'h0ABC_D11D;
    mem[32'h0001_0010] = 32'h0002_2023;
    mem[32'h0002_2004] = 32'h0055_5027;
    mem[32'h0001_00C0] = 32'h7FC0_0083;
    mem[32'h0003_0004] = 32'h0002_0027;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R10", "no memory request after reset", {31'b0, mem_req}, 32'd0);
    chk("R10", "no response after reset", {31'b0, rsp_valid}, 32'd0);

    walk(32'h0040_3ABC, 0, 1, 20'h00010, 0); // R4 user read, no write-back
    walk(32'h0040_3ABC, 1, 1, 20'h00010, 1); // R6 sets dirty in table entry
    walk(32'h0040_3ABC, 1, 1, 20'h00010, 2); // R6 already dirty: no write
    walk(32'h0080_5123, 0, 0, 20'h00010, 1); // R6 both entries updated, R11 attrs
    walk(32'h0080_5123, 1, 0, 20'h00010, 0); // R5 write to read-only page
    walk(32'h00C0_0000, 0, 0, 20'h00010, 1); // R2 directory not present
    walk(32'h0040_7000, 1, 1, 20'h00010, 0); // R2 table entry not present
    walk(32'h0100_1FFF, 0, 1, 20'h00010, 2); // R5 directory denies user
    walk(32'h0100_1FFF, 1, 0, 20'h00010, 0); // R5 supervisor write allowed
    walk(32'h0C12_3456, 0, 0, 20'h00010, 1); // R3 large page, accessed set
    walk(32'h0C12_3456, 1, 0, 20'h00010, 0); // R3 large page dirty write-back
    walk(32'h0C12_3456, 0, 1, 20'h00010, 1); // R5 user denied on large page
    walk(32'h0040_3ABC, 0, 1, 20'h00030, 0); // R1 other directory base
    finish_run();
  end
endmodule